// File: doc/BRIEF.md
# SPI Flash Transaction Monitor

This block watches the byte stream between an SPI master and a serial NOR flash without taking part in it. An upstream deserializer hands it one completed byte pair per strobe: the byte shifted out on MOSI and the byte shifted back on MISO. It also sees the live chip-select level. From these it follows each flash command from its opcode to its end and emits one structured event per byte of interest.

Four commands are understood: read, page program, read status and sector erase. For the three addressed commands it assembles the 24-bit address, most significant byte first. It flags a sector erase whose address is not on a 4 KiB boundary. Payload bytes are reported from the direction that carries them. Status bytes are split into named fields. An opcode outside the set is reported as unknown. Chip-select going high ends any command at once, and a command cut short inside its address bytes is reported as truncated.

Events appear on a one-cycle strobe with a type code, an address, a data byte, a byte index and an error flag. No back-pressure is possible: a consumer that wants the events must take them when they appear.

Top module: `spi_flash_txn_monitor`

## Requirements
- R1: Reset (`rst_n` low, sampled at the clock edge) puts the monitor in idle with the address and counters cleared and `evt_valid` low. A byte that arrives after reset is taken as an opcode.
- R2: In idle, a byte strobe with `cs_n` low takes MOSI as the opcode. The recognised values are 0x03 read, 0x02 page program, 0x05 read status and 0x20 sector erase. Each gives a type 0 (command) event with the opcode in `evt_data` and index 0.
- R3: Any other opcode gives a type 4 (unknown) event with the opcode in `evt_data`, and the monitor stays idle. The next byte, even under the same chip-select, is taken as an opcode.
- R4: For read, page program and sector erase, the next three MOSI bytes form the address, first byte in bits 23:16. The third byte gives a type 1 (address) event with the full address, index 2 and `evt_data` zero.
- R5: On a sector-erase address event, `evt_err` is 1 exactly when address bits 11:0 are not all zero. `evt_err` is 0 on every other event. After its address, a sector erase returns to idle.
- R6: After a read-status opcode, each byte gives a type 3 (status) event with the MISO byte and an index that counts from 0 and saturates at 255. This continues as long as `cs_n` stays low. While `evt_data` holds a status byte, `stat_wip` is bit 0, `stat_wel` is bit 1, `stat_bp` is bits 5:2, `stat_cpm` is bit 6 and `stat_srwd` is bit 7.
- R7: After the address, each byte gives a type 2 (data) event with a payload index counting from 0. The data byte is taken from MOSI for page program and from MISO for read.
- R8: A read or page program closes after its 256th payload byte (index 255), even with `cs_n` still low. The following byte is taken as an opcode.
- R9: `cs_n` high ends any command at once and discards a byte strobed in the same cycle. If the address bytes were not all received, it raises a type 5 (truncated) event whose index is the number of address bytes received. In any other phase it ends without an event.
- R10: Events other than the address event carry `evt_addr` zero. The address accumulator is cleared after each address event and at each end of a command, so each address depends only on its own three bytes.
- R11: Each event is a single-cycle pulse in the cycle after the clock edge that sampled the byte or chip-select change that caused it. A cycle with no byte strobe and no chip-select rise gives no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: a byte pair has completed |
| mosi_byte | input | 8 | Byte sent by the master |
| miso_byte | input | 8 | Byte returned by the flash |
| cs_n | input | 1 | Chip-select level, active low |
| evt_valid | output | 1 | Event strobe |
| evt_type | output | 3 | 0 command, 1 address, 2 data, 3 status, 4 unknown, 5 truncated |
| evt_addr | output | 24 | Assembled address on address events, zero otherwise |
| evt_data | output | 8 | Opcode, payload byte or status byte |
| evt_index | output | 8 | Byte index within the current phase |
| evt_err | output | 1 | Sector-erase address not 4 KiB aligned |
| stat_wip | output | 1 | Status field: write in progress |
| stat_wel | output | 1 | Status field: write-enable latch |
| stat_bp | output | 4 | Status field: block-protect bits |
| stat_cpm | output | 1 | Status field: continuous-program mode |
| stat_srwd | output | 1 | Status field: status-register write disable |

## Verification
The two functions that can fall in the same cycle are byte capture and command termination. This happens when the deserializer strobes a byte in the very cycle that `cs_n` rises. The bench provokes it after two address bytes of a sector erase, with the strobe and the rising chip-select driven together. It judges the result by a single truncated event reporting two address bytes, no address event, and a later byte under a new chip-select being decoded as an opcode. A second strobe while `cs_n` is still high must produce no event at all.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef enum logic [2:0] {
        EV_CMD     = 3'd0,
        EV_ADDR    = 3'd1,
        EV_DATA    = 3'd2,
        EV_STATUS  = 3'd3,
        EV_UNKNOWN = 3'd4,
        EV_TRUNC   = 3'd5
    } ev_type_e;

    typedef enum logic [1:0] {
        K_READ,
        K_PROG,
        K_STAT,
        K_ERASE
    } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_STAT
    } phase_e;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_ERASE = 8'h20;

endpackage

// File: rtl/spi_mon_opdec.sv
module spi_mon_opdec
    import spi_mon_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       known,
    output op_kind_e   kind
);

    always_comb begin
        known = 1'b1;
        kind  = K_READ;
        unique case (opcode)
            OPC_READ:  kind = K_READ;
            OPC_PROG:  kind = K_PROG;
            OPC_STAT:  kind = K_STAT;
            OPC_ERASE: kind = K_ERASE;
            default:   known = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_mon_align_chk.sv
module spi_mon_align_chk #(
    parameter int ADDR_W       = 24,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned
);

    localparam int SECT_BITS = $clog2(SECTOR_BYTES);

    generate
        if (SECT_BITS == 0) begin : g_none
            assign misaligned = 1'b0;
        end else begin : g_bits
            assign misaligned = |addr[SECT_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/spi_mon_status_split.sv
module spi_mon_status_split (
    input  logic [7:0] status,
    output logic       wip,
    output logic       wel,
    output logic [3:0] bp,
    output logic       cpm,
    output logic       srwd
);

    always_comb begin
        wip  = status[0];
        wel  = status[1];
        bp   = status[5:2];
        cpm  = status[6];
        srwd = status[7];
    end

endmodule

// File: rtl/spi_flash_txn_monitor.sv
module spi_flash_txn_monitor
    import spi_mon_pkg::*;
#(
    parameter int ADDR_BYTES   = 3,
    parameter int PAYLOAD_MAX  = 256,
    parameter int SECTOR_BYTES = 4096
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_valid,
    input  logic [7:0]                  mosi_byte,
    input  logic [7:0]                  miso_byte,
    input  logic                        cs_n,
    output logic                        evt_valid,
    output logic [2:0]                  evt_type,
    output logic [8*ADDR_BYTES-1:0]     evt_addr,
    output logic [7:0]                  evt_data,
    output logic [$clog2(PAYLOAD_MAX)-1:0] evt_index,
    output logic                        evt_err,
    output logic                        stat_wip,
    output logic                        stat_wel,
    output logic [3:0]                  stat_bp,
    output logic                        stat_cpm,
    output logic                        stat_srwd
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = $clog2(PAYLOAD_MAX);
    localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(ADDR_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_PAY  = IDX_W'(PAYLOAD_MAX - 1);
    localparam logic [IDX_W-1:0] IDX_SAT   = '1;

    typedef struct packed {
        phase_e            phase;
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  cnt;
        logic              ev_valid;
        ev_type_e          ev_type;
        logic [ADDR_W-1:0] ev_addr;
        logic [7:0]        ev_data;
        logic [IDX_W-1:0]  ev_idx;
        logic              ev_err;
    } mon_state_t;

    mon_state_t        st_d, st_q;
    logic              op_known;
    op_kind_e          op_kind;
    logic [ADDR_W-1:0] addr_shift;
    logic              addr_misaligned;

    // Shift-in of one address byte: earlier bytes move toward the top.
    assign addr_shift = {st_q.addr[ADDR_W-9:0], mosi_byte};

    spi_mon_opdec u_opdec (
        .opcode (mosi_byte),
        .known  (op_known),
        .kind   (op_kind)
    );

    spi_mon_align_chk #(
        .ADDR_W       (ADDR_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_align (
        .addr       (addr_shift),
        .misaligned (addr_misaligned)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ev_valid = 1'b0;
        st_d.ev_type  = EV_CMD;
        st_d.ev_addr  = '0;
        st_d.ev_data  = '0;
        st_d.ev_idx   = '0;
        st_d.ev_err   = 1'b0;

        if (cs_n) begin
            // Chip-select high wins over a byte strobed in the same cycle.
            if (st_q.phase == PH_ADDR) begin
                st_d.ev_valid = 1'b1;
                st_d.ev_type  = EV_TRUNC;
                st_d.ev_idx   = st_q.cnt;
            end
            st_d.phase = PH_IDLE;
            st_d.addr  = '0;
            st_d.cnt   = '0;
        end else if (byte_valid) begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.ev_valid = 1'b1;
                    st_d.ev_data  = mosi_byte;
                    st_d.addr     = '0;
                    st_d.cnt      = '0;
                    if (op_known) begin
                        st_d.ev_type = EV_CMD;
                        st_d.kind    = op_kind;
                        st_d.phase   = (op_kind == K_STAT) ? PH_STAT : PH_ADDR;
                    end else begin
                        st_d.ev_type = EV_UNKNOWN;
                    end
                end
                PH_ADDR: begin
                    if (st_q.cnt == LAST_ADDR) begin
                        st_d.ev_valid = 1'b1;
                        st_d.ev_type  = EV_ADDR;
                        st_d.ev_addr  = addr_shift;
                        st_d.ev_idx   = st_q.cnt;
                        st_d.ev_err   = (st_q.kind == K_ERASE) && addr_misaligned;
                        st_d.addr     = '0;
                        st_d.cnt      = '0;
                        st_d.phase    = (st_q.kind == K_ERASE) ? PH_IDLE : PH_DATA;
                    end else begin
                        st_d.addr = addr_shift;
                        st_d.cnt  = st_q.cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    st_d.ev_valid = 1'b1;
                    st_d.ev_type  = EV_DATA;
                    st_d.ev_data  = (st_q.kind == K_PROG) ? mosi_byte : miso_byte;
                    st_d.ev_idx   = st_q.cnt;
                    if (st_q.cnt == LAST_PAY) begin
                        st_d.phase = PH_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_STAT: begin
                    st_d.ev_valid = 1'b1;
                    st_d.ev_type  = EV_STATUS;
                    st_d.ev_data  = miso_byte;
                    st_d.ev_idx   = st_q.cnt;
                    if (st_q.cnt != IDX_SAT) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.kind     <= K_READ;
            st_q.addr     <= '0;
            st_q.cnt      <= '0;
            st_q.ev_valid <= 1'b0;
            st_q.ev_type  <= EV_CMD;
            st_q.ev_addr  <= '0;
            st_q.ev_data  <= '0;
            st_q.ev_idx   <= '0;
            st_q.ev_err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_valid = st_q.ev_valid;
    assign evt_type  = st_q.ev_type;
    assign evt_addr  = st_q.ev_addr;
    assign evt_data  = st_q.ev_data;
    assign evt_index = st_q.ev_idx;
    assign evt_err   = st_q.ev_err;

    spi_mon_status_split u_split (
        .status (st_q.ev_data),
        .wip    (stat_wip),
        .wel    (stat_wel),
        .bp     (stat_bp),
        .cpm    (stat_cpm),
        .srwd   (stat_srwd)
    );

endmodule

// File: rtl/spi_mon_checker.sv
module spi_mon_checker #(
    parameter int ADDR_W    = 24,
    parameter int SECT_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              cs_n,
    input logic              evt_valid,
    input logic [2:0]        evt_type,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              evt_err
);

    localparam logic [2:0] T_ADDR  = 3'd1;
    localparam logic [2:0] T_TRUNC = 3'd5;

    a_r11_event_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type != T_TRUNC) |-> $past(byte_valid && !cs_n));

    a_r9_trunc_from_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type == T_TRUNC) |-> $past(cs_n));

    a_r9_cs_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cs_n, 2)) |-> !evt_valid);

    a_r11_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_type <= T_TRUNC));

    a_r5_err_on_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> (evt_valid && evt_type == T_ADDR));

    a_r5_err_means_offset: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> (evt_addr[SECT_BITS-1:0] != '0));

    a_r10_addr_zero_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_type != T_ADDR) |-> (evt_addr == '0));

endmodule

bind spi_flash_txn_monitor spi_mon_checker #(
    .ADDR_W    (8 * ADDR_BYTES),
    .SECT_BITS ($clog2(SECTOR_BYTES))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .cs_n       (cs_n),
    .evt_valid  (evt_valid),
    .evt_type   (evt_type),
    .evt_addr   (evt_addr),
    .evt_err    (evt_err)
);

// File: tb/tb_spi_flash_txn_monitor.sv
module tb_spi_flash_txn_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_valid;
    logic [7:0]  mosi_byte;
    logic [7:0]  miso_byte;
    logic        cs_n;
    logic        evt_valid;
    logic [2:0]  evt_type;
    logic [23:0] evt_addr;
    logic [7:0]  evt_data;
    logic [7:0]  evt_index;
    logic        evt_err;
    logic        stat_wip, stat_wel, stat_cpm, stat_srwd;
    logic [3:0]  stat_bp;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spi_flash_txn_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .mosi_byte  (mosi_byte),
        .miso_byte  (miso_byte),
        .cs_n       (cs_n),
        .evt_valid  (evt_valid),
        .evt_type   (evt_type),
        .evt_addr   (evt_addr),
        .evt_data   (evt_data),
        .evt_index  (evt_index),
        .evt_err    (evt_err),
        .stat_wip   (stat_wip),
        .stat_wel   (stat_wel),
        .stat_bp    (stat_bp),
        .stat_cpm   (stat_cpm),
        .stat_srwd  (stat_srwd)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        cs;
        logic        bv;
        logic [7:0]  mo;
        logic [7:0]  mi;
        logic        ev;
        logic [2:0]  ty;
        logic [23:0] ad;
        logic [7:0]  da;
        logic [7:0]  ix;
        logic        er;
    } vec_t;

    localparam int NV = 43;
    // Fields: req, cs_n, strobe, mosi, miso | valid, type, addr, data, index, err
    localparam vec_t VEC [NV] = '{
        // R2/R4/R7: read at 0x123456, two bytes back on MISO
        '{4'd2,  1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 3'd0, 24'h0,      8'h03, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h12, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h34, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h56, 8'h00, 1'b1, 3'd1, 24'h123456, 8'h00, 8'd2, 1'b0},
        '{4'd7,  1'b0, 1'b1, 8'hFF, 8'hA5, 1'b1, 3'd2, 24'h0,      8'hA5, 8'd0, 1'b0},
        '{4'd11, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd7,  1'b0, 1'b1, 8'hFF, 8'h5A, 1'b1, 3'd2, 24'h0,      8'h5A, 8'd1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R7: page program at 0x000100, data from MOSI
        '{4'd2,  1'b0, 1'b1, 8'h02, 8'h00, 1'b1, 3'd0, 24'h0,      8'h02, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h01, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 3'd1, 24'h000100, 8'h00, 8'd2, 1'b0},
        '{4'd7,  1'b0, 1'b1, 8'h11, 8'h99, 1'b1, 3'd2, 24'h0,      8'h11, 8'd0, 1'b0},
        '{4'd7,  1'b0, 1'b1, 8'h22, 8'h99, 1'b1, 3'd2, 24'h0,      8'h22, 8'd1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R5: aligned erase, then back to idle: next byte is an opcode
        '{4'd2,  1'b0, 1'b1, 8'h20, 8'h00, 1'b1, 3'd0, 24'h0,      8'h20, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h30, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd5,  1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 3'd1, 24'h003000, 8'h00, 8'd2, 1'b0},
        '{4'd5,  1'b0, 1'b1, 8'h05, 8'h00, 1'b1, 3'd0, 24'h0,      8'h05, 8'd0, 1'b0},
        // R6: status bytes from MISO
        '{4'd6,  1'b0, 1'b1, 8'h00, 8'h83, 1'b1, 3'd3, 24'h0,      8'h83, 8'd0, 1'b0},
        '{4'd6,  1'b0, 1'b1, 8'h00, 8'h02, 1'b1, 3'd3, 24'h0,      8'h02, 8'd1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R5/R10: misaligned erase, fresh address
        '{4'd2,  1'b0, 1'b1, 8'h20, 8'h00, 1'b1, 3'd0, 24'h0,      8'h20, 8'd0, 1'b0},
        '{4'd10, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd10, 1'b0, 1'b1, 8'h10, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd5,  1'b0, 1'b1, 8'h01, 8'h00, 1'b1, 3'd1, 24'h001001, 8'h00, 8'd2, 1'b1},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R3: unknown opcode stays idle; next byte is an opcode
        '{4'd3,  1'b0, 1'b1, 8'h9F, 8'h00, 1'b1, 3'd4, 24'h0,      8'h9F, 8'd0, 1'b0},
        '{4'd3,  1'b0, 1'b1, 8'h05, 8'h00, 1'b1, 3'd0, 24'h0,      8'h05, 8'd0, 1'b0},
        '{4'd6,  1'b0, 1'b1, 8'h00, 8'h01, 1'b1, 3'd3, 24'h0,      8'h01, 8'd0, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R9: truncated inside the address
        '{4'd2,  1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 3'd0, 24'h0,      8'h03, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h12, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 3'd5, 24'h0,      8'h00, 8'd1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        // R9: byte strobe and chip-select rise in the same cycle
        '{4'd2,  1'b0, 1'b1, 8'h20, 8'h00, 1'b1, 3'd0, 24'h0,      8'h20, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd4,  1'b0, 1'b1, 8'h10, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd9,  1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 3'd5, 24'h0,      8'h00, 8'd2, 1'b0},
        '{4'd9,  1'b1, 1'b1, 8'h03, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0},
        '{4'd9,  1'b0, 1'b1, 8'h05, 8'h00, 1'b1, 3'd0, 24'h0,      8'h05, 8'd0, 1'b0},
        '{4'd9,  1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 24'h0,      8'h00, 8'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic cs, input logic bv, input logic [7:0] mo, input logic [7:0] mi);
        @(negedge clk);
        cs_n       = cs;
        byte_valid = bv;
        mosi_byte  = mo;
        miso_byte  = mi;
        @(posedge clk);
        #2;
    endtask

    task automatic chk_event(input string tag, input logic [2:0] ty, input logic [7:0] da,
                             input logic [7:0] ix);
        chk({tag, " valid"}, 32'(evt_valid), 32'd1);
        chk({tag, " type"},  32'(evt_type),  32'(ty));
        chk({tag, " data"},  32'(evt_data),  32'(da));
        chk({tag, " index"}, 32'(evt_index), 32'(ix));
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        cs_n       = 1'b1;
        byte_valid = 1'b0;
        mosi_byte  = 8'h00;
        miso_byte  = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 reset valid", 32'(evt_valid), 32'd0);
        chk("R1 reset addr",  32'(evt_addr),  32'd0);
        chk("R1 reset err",   32'(evt_err),   32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            cyc(VEC[i].cs, VEC[i].bv, VEC[i].mo, VEC[i].mi);
            chk({tag, " valid"}, 32'(evt_valid), 32'(VEC[i].ev));
            if (VEC[i].ev) begin
                chk({tag, " type"},  32'(evt_type),  32'(VEC[i].ty));
                chk({tag, " addr"},  32'(evt_addr),  32'(VEC[i].ad));
                chk({tag, " data"},  32'(evt_data),  32'(VEC[i].da));
                chk({tag, " index"}, 32'(evt_index), 32'(VEC[i].ix));
                chk({tag, " err"},   32'(evt_err),   32'(VEC[i].er));
            end
        end

        // R6: status fields on two patterns
        cyc(1'b0, 1'b1, 8'h05, 8'h00);
        chk_event("R6 cmd", 3'd0, 8'h05, 8'd0);
        cyc(1'b0, 1'b1, 8'h00, 8'h7C);
        chk("R6 wip 7C",  32'(stat_wip),  32'd0);
        chk("R6 wel 7C",  32'(stat_wel),  32'd0);
        chk("R6 bp 7C",   32'(stat_bp),   32'hF);
        chk("R6 cpm 7C",  32'(stat_cpm),  32'd1);
        chk("R6 srwd 7C", 32'(stat_srwd), 32'd0);
        cyc(1'b0, 1'b1, 8'h00, 8'h83);
        chk("R6 wip 83",  32'(stat_wip),  32'd1);
        chk("R6 wel 83",  32'(stat_wel),  32'd1);
        chk("R6 bp 83",   32'(stat_bp),   32'h0);
        chk("R6 cpm 83",  32'(stat_cpm),  32'd0);
        chk("R6 srwd 83", 32'(stat_srwd), 32'd1);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);

        // R8: payload limit closes the read with chip-select still low
        cyc(1'b0, 1'b1, 8'h03, 8'h00);
        cyc(1'b0, 1'b1, 8'h00, 8'h00);
        cyc(1'b0, 1'b1, 8'h00, 8'h00);
        cyc(1'b0, 1'b1, 8'h00, 8'h00);
        chk("R8 addr event", 32'(evt_type), 32'd1);
        for (int k = 0; k < 256; k++) begin
            cyc(1'b0, 1'b1, 8'hEE, 8'(k ^ 8'h5C));
            chk_event("R8 payload", 3'd2, 8'(k ^ 8'h5C), 8'(k));
        end
        cyc(1'b0, 1'b1, 8'h05, 8'h00);
        chk_event("R8 after limit", 3'd0, 8'h05, 8'd0);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);

        // R1: reset in the middle of an address
        cyc(1'b0, 1'b1, 8'h03, 8'h00);
        cyc(1'b0, 1'b1, 8'h12, 8'h00);
        @(negedge clk);
        rst_n      = 1'b0;
        byte_valid = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 mid reset valid", 32'(evt_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 8'h20, 8'h00);
        chk_event("R1 opcode after reset", 3'd0, 8'h20, 8'd0);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);
        chk("R9 trunc after reset", 32'(evt_index), 32'd0);

        finish_run();
    end

endmodule